// File: doc/BRIEF.md
# Cascadable Serial Configuration Streamer

This block feeds a stored configuration image to an SRAM-based FPGA that loads itself in master serial mode. The FPGA supplies the clock, a chip-select (`ce_n`) and one shared reset/output-enable pin (`rst_oe`). On each clock edge the block puts out one bit of the image on a tri-stated data line. Within a byte the bits go LSB first, and bytes go in ascending address order. The image lives in an external array that the block reads through a synchronous byte read port. A read is issued one bit before the current byte runs out, so the bit stream has no gaps.

Devices of this kind can be chained. When the last bit of this device has gone out, it lets go of the data line and pulls its chain-enable output (`ceo_n`) low, which selects the next device. The meaning of `rst_oe` is set by a polarity bit. That bit is captured only during the power-on sequence, so a new setting takes effect only after a power cycle. A ready flag stays low for the whole power-on sequence. Readout stops and the outputs are released whenever serial readout is disabled (`ser_en` low) or the part is powered down (`pwr_dn` high).

The controller is a state machine with five states. ST_POR waits for the power-on sequence. ST_RST holds the counters clear. ST_FILL loads the first byte. ST_STREAM shifts bits out. ST_DONE is entered when the image is exhausted. The transitions are:
- POR→RST when ready rises.
- Any state→RST while the reset level is present.
- RST→FILL when the reset level is released.
- FILL→STREAM unconditionally.
- STREAM→DONE on the advance of the last bit.
- DONE stays in DONE until the next reset level.

Top module: `cfg_serial_reader`

## Requirements
- R1: In ST_STREAM, with `ce_n` low and output enable active, `data_o` shows bit k of the image and `data_drv` is 1. Image bit k is bit (k mod 8) of byte floor(k/8). Each rising edge moves to bit k+1, with no idle cycle at byte boundaries.
- R2: While the reset level is on `rst_oe`, `data_drv` is 0 whatever `ce_n` is, and the bit and byte counters clear. After release, the first edge enters ST_FILL (not driving). From the second edge on, bit 0 of byte 0 is presented.
- R3: While `ce_n` is high, `data_drv` is 0 and the stream position does not move.
- R4: After the last bit has been advanced, `ceo_n` equals `ce_n`. `ceo_n` returns high at the next reset level and stays high until the whole image has been read again.
- R5: Once the last bit has been sent, `data_drv` stays 0.
- R6: With the captured polarity 0, `rst_oe`=0 is the reset level and 1 is output enable. With polarity 1 both meanings swap. `pol_cfg` is sampled only while `ready` is low, so changing it afterwards has no effect.
- R7: `por_n` low clears everything asynchronously. `ready` becomes 1 exactly POR_CYCLES rising edges after `por_n` is released, and nothing is driven before then.
- R8: While `ser_en` is low, `data_drv` is 0, `ceo_n` is 1 and the stream position is held.
- R9: While `pwr_dn` is high, `data_drv` is 0, `ceo_n` is 1 and the stream position is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from the FPGA |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pol_cfg | input | 1 | Stored reset/output-enable polarity (1 = inverted) |
| ser_en | input | 1 | Serial readout enable, high for readout |
| pwr_dn | input | 1 | Power-down request, active high |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Shared reset / output-enable pin |
| ready | output | 1 | Power-on sequence complete |
| data_o | output | 1 | Serial data value |
| data_drv | output | 1 | Data driver enable (0 = high impedance) |
| ceo_n | output | 1 | Chain enable to next device, active low |
| rd_en | output | 1 | Byte read strobe to the array |
| rd_addr | output | ADDR_W | Byte read address |
| rd_data | input | 8 | Byte returned one cycle after `rd_en` |

## Verification
A wrong bit index or byte address shows up on `data_o` at the very next presented bit, and it stays wrong for the rest of the image. Random `ce_n` stalls therefore expose a counter that moves during a stall as soon as the stream resumes. A missing or late prefetch corrupts the first bit of the following byte, eight edges later. A wrong terminal count or a wrong DONE state shows within one cycle as `ceo_n` falling early or late, or as `data_drv` staying on after the last bit.

// File: rtl/cfgsr_pkg.sv
package cfgsr_pkg;
    typedef enum logic [2:0] {
        ST_POR    = 3'd0,
        ST_RST    = 3'd1,
        ST_FILL   = 3'd2,
        ST_STREAM = 3'd3,
        ST_DONE   = 3'd4
    } rd_state_e;
endpackage

// File: rtl/cfgsr_por.sv
module cfgsr_por #(
    parameter int POR_CYCLES = 8,
    localparam int CW = $clog2(POR_CYCLES + 1)
) (
    input  logic clk,
    input  logic por_n,
    input  logic pol_cfg,
    output logic ready,
    output logic pol_inv
);
    logic [CW-1:0] cnt_q;
    logic          ready_q;
    logic          pol_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
            pol_q   <= 1'b0;
        end else if (!ready_q) begin
            pol_q <= pol_cfg;
            if (cnt_q == CW'(POR_CYCLES - 1)) ready_q <= 1'b1;
            else                              cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign ready   = ready_q;
    assign pol_inv = pol_q;

    // R6
    pol_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
        ready_q |=> (ready_q && $stable(pol_q)));
endmodule

// File: rtl/cfgsr_pos.sv
module cfgsr_pos #(
    parameter int DEPTH_BYTES = 16,
    localparam int ADDR_W = $clog2(DEPTH_BYTES)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              clr,
    input  logic              adv,
    output logic [2:0]        bit_idx,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              last_byte,
    output logic              at_end
);
    logic [2:0]        bit_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            bit_q  <= '0;
            addr_q <= '0;
        end else if (clr) begin
            bit_q  <= '0;
            addr_q <= '0;
        end else if (adv) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) addr_q <= addr_q + 1'b1;
        end
    end

    assign bit_idx   = bit_q;
    assign byte_addr = addr_q;
    assign last_byte = (addr_q == ADDR_W'(DEPTH_BYTES - 1));
    assign at_end    = last_byte && (bit_q == 3'd7);

    // R2
    pos_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (bit_q == 3'd0 && addr_q == '0));
    // R3
    pos_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!clr && !adv) |=> ($stable(bit_q) && $stable(addr_q)));
endmodule

// File: rtl/cfg_serial_reader.sv
module cfg_serial_reader
    import cfgsr_pkg::*;
#(
    parameter int DEPTH_BYTES = 16,
    parameter int POR_CYCLES  = 8,
    localparam int ADDR_W     = $clog2(DEPTH_BYTES)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              pol_cfg,
    input  logic              ser_en,
    input  logic              pwr_dn,
    input  logic              ce_n,
    input  logic              rst_oe,
    output logic              ready,
    output logic              data_o,
    output logic              data_drv,
    output logic              ceo_n,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    rd_state_e         state_q, state_d;
    logic              pol_inv;
    logic              live, oe_act, at_rst, adv;
    logic [2:0]        bit_idx;
    logic [ADDR_W-1:0] byte_addr;
    logic              last_byte, at_end;
    logic [7:0]        cur_q;

    cfgsr_por #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk     (clk),
        .por_n   (por_n),
        .pol_cfg (pol_cfg),
        .ready   (ready),
        .pol_inv (pol_inv)
    );

    assign live   = ready && ser_en && !pwr_dn;
    assign oe_act = rst_oe ^ pol_inv;
    assign at_rst = live && !oe_act;
    assign adv    = live && oe_act && !ce_n && (state_q == ST_STREAM);

    cfgsr_pos #(.DEPTH_BYTES(DEPTH_BYTES)) u_pos (
        .clk       (clk),
        .por_n     (por_n),
        .clr       (at_rst),
        .adv       (adv),
        .bit_idx   (bit_idx),
        .byte_addr (byte_addr),
        .last_byte (last_byte),
        .at_end    (at_end)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR:    if (ready) state_d = ST_RST;
            ST_RST:    if (live && oe_act) state_d = ST_FILL;
            ST_FILL:   if (live) state_d = ST_STREAM;
            ST_STREAM: if (adv && at_end) state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_POR;
        endcase
        if (at_rst) state_d = ST_RST;
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_POR;
        else        state_q <= state_d;
    end

    // Current byte: loaded in FILL, then reloaded from the prefetch at each byte boundary
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                           cur_q <= '0;
        else if (state_q == ST_FILL && live)  cur_q <= rd_data;
        else if (adv && bit_idx == 3'd7)      cur_q <= rd_data;
    end

    // Outputs
    always_comb begin
        data_drv = live && oe_act && !ce_n && (state_q == ST_STREAM);
        data_o   = data_drv ? cur_q[bit_idx] : 1'b0;
        ceo_n    = !(live && oe_act && !ce_n && (state_q == ST_DONE));
        rd_en    = 1'b0;
        rd_addr  = '0;
        unique case (state_q)
            ST_POR, ST_RST: rd_en = 1'b1;
            ST_STREAM: begin
                rd_en   = adv && (bit_idx == 3'd6) && !last_byte;
                rd_addr = byte_addr + 1'b1;
            end
            default: ;
        endcase
    end

    // R3
    ce_float_chk: assert property (@(posedge clk) disable iff (!por_n)
        ce_n |-> !data_drv);
    // R5
    done_float_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ceo_n |-> !data_drv);
    // R8
    ser_off_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ser_en |-> (!data_drv && ceo_n));
    // R9
    pwr_off_chk: assert property (@(posedge clk) disable iff (!por_n)
        pwr_dn |-> (!data_drv && ceo_n));
    // R7
    por_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ready |-> (!data_drv && ceo_n));
    // R2
    rst_enter_chk: assert property (@(posedge clk) disable iff (!por_n)
        at_rst |=> (state_q == ST_RST));
    // R4
    done_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
        (adv && at_end) |=> (state_q == ST_DONE));
endmodule

// File: tb/tb_cfg_serial_reader.sv
module tb_cfg_serial_reader;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int PORC       = 8;
    localparam int TOTAL      = DEPTH * 8;
    localparam int AW         = $clog2(DEPTH);

    logic clk = 1'b0;
    logic por_n, pol_cfg, ser_en, pwr_dn, ce_n, rst_oe;
    logic ready, data_o, data_drv, ceo_n, rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic [7:0]    mem [DEPTH];

    int nvec = 0;
    int nerr = 0;
    int k    = 0;
    logic pol_now = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_serial_reader #(.DEPTH_BYTES(DEPTH), .POR_CYCLES(PORC)) dut (
        .clk(clk), .por_n(por_n), .pol_cfg(pol_cfg), .ser_en(ser_en),
        .pwr_dn(pwr_dn), .ce_n(ce_n), .rst_oe(rst_oe), .ready(ready),
        .data_o(data_o), .data_drv(data_drv), .ceo_n(ceo_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    function automatic logic exp_bit(int idx);
        logic [7:0] b;
        b = mem[idx / 8];
        return b[idx % 8];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h (bit %0d)", req, act, exp, k);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic start_stream();
        ce_n   = 1'b0;
        rst_oe = ~pol_now;
        tick();
        check("R2 fill not driving", {31'd0, data_drv}, 0);
        tick();
        k = 0;
    endtask

    task automatic run_to(int target, bit rnd);
        while (k < target) begin
            ce_n = rnd ? ($urandom % 4 == 0) : 1'b0;
            #1;
            if (ce_n) begin
                check("R3 float while ce_n high", {31'd0, data_drv}, 0);
            end else begin
                check("R1 drive", {31'd0, data_drv}, 1);
                check("R1 data bit", {31'd0, data_o}, {31'd0, exp_bit(k)});
                check("R4 ceo high mid-stream", {31'd0, ceo_n}, 1);
            end
            tick();
            if (!ce_n) k++;
        end
        ce_n = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'($urandom);
        por_n = 0; pol_cfg = 0; ser_en = 1; pwr_dn = 0; ce_n = 1; rst_oe = 0;
        tick(); tick();
        check("R7 ready low in reset", {31'd0, ready}, 0);
        por_n = 1;
        for (int i = 1; i <= PORC; i++) begin
            tick();
            if (i == PORC - 1) check("R7 ready still low", {31'd0, ready}, 0);
            if (i == PORC)     check("R7 ready high", {31'd0, ready}, 1);
        end
        tick(); tick();

        // R1 with random CE stalls, then reset mid-stream (R2)
        start_stream();
        run_to(20, 1'b1);
        rst_oe = 1'b0;
        #1;
        check("R2 float on reset level", {31'd0, data_drv}, 0);
        tick(); tick();
        start_stream();
        run_to(10, 1'b0);

        // R8 serial disable holds position
        ser_en = 1'b0;
        #1;
        check("R8 no drive", {31'd0, data_drv}, 0);
        check("R8 ceo high", {31'd0, ceo_n}, 1);
        tick(); tick(); tick();
        ser_en = 1'b1;
        run_to(15, 1'b0);

        // R9 power-down holds position
        pwr_dn = 1'b1;
        #1;
        check("R9 no drive", {31'd0, data_drv}, 0);
        check("R9 ceo high", {31'd0, ceo_n}, 1);
        tick(); tick();
        pwr_dn = 1'b0;
        run_to(22, 1'b1);

        // R6 late polarity change has no effect
        pol_cfg = 1'b1;
        run_to(40, 1'b1);
        run_to(TOTAL, 1'b1);

        // R4 / R5 end of image
        check("R5 float after last bit", {31'd0, data_drv}, 0);
        check("R4 ceo low at end", {31'd0, ceo_n}, 0);
        ce_n = 1'b1;
        #1;
        check("R4 ceo follows ce high", {31'd0, ceo_n}, 1);
        tick();
        ce_n = 1'b0;
        #1;
        check("R4 ceo follows ce low", {31'd0, ceo_n}, 0);
        tick(); tick();
        check("R5 still floating", {31'd0, data_drv}, 0);
        check("R4 ceo stays low", {31'd0, ceo_n}, 0);

        // R2 reset while CE high clears, R4 ceo back high
        ce_n = 1'b1;
        rst_oe = 1'b0;
        tick();
        ce_n = 1'b0;
        #1;
        check("R4 ceo high after reset", {31'd0, ceo_n}, 1);
        ce_n = 1'b1;
        rst_oe = 1'b1;
        tick(); tick();
        check("R3 float ce high", {31'd0, data_drv}, 0);
        k = 0;
        run_to(12, 1'b0);

        // R6/R7 power cycle with inverted polarity
        por_n = 1'b0;
        #1;
        check("R7 ready drops", {31'd0, ready}, 0);
        tick();
        rst_oe = 1'b1;
        por_n = 1'b1;
        for (int i = 0; i < PORC + 3; i++) tick();
        check("R6 high is reset level", {31'd0, data_drv}, 0);
        pol_now = 1'b1;
        start_stream();
        run_to(40, 1'b1);
        rst_oe = 1'b1;
        #1;
        check("R6 inverted reset floats", {31'd0, data_drv}, 0);
        tick();

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule